// File: doc/BRIEF.md
# Interline CCD Drive Sequencer

This block produces the digital drive pattern for a four-phase interline CCD that reads out one field at a time and has an electronic shutter. A pixel-position counter and a line counter run from the block clock. The counts decode into a two-bit level code for each vertical phase, two horizontal shift phases, a reset-gate strobe, a substrate drain strobe, a blanking flag and a field flag. An external level shifter turns each code and strobe into drive voltages.

One pixel takes two clock cycles. Line and field starts come from the internal counters. The optional `hd_i` and `vd_i` strobes force a new line or a new field. Even fields are one line longer than odd fields to allow for the single vertical dummy stage. The shutter input gives the last line that still drains charge. Each field captures that value when it starts.

Top module: `ccd_timing_gen`

## Requirements
- R1: While `rst_n` is low, `vlev_o` holds the idle pattern 8'h05, `h1_o` is 1, `h2_o`, `rg_o` and `sub_o` are 0, `blk_o` is 1 and `fld_o` is 0. After release, counting starts at pixel 0 of line 0 of an odd field.
- R2: The pixel position counts 0 to LINE_LEN-1 and then wraps, which advances the line. The decoded outputs lag the counters by one clock. `fld_o` is the counter's own field bit.
- R3: An odd field (`fld_o`=0) has FIELD_LINES lines and an even field (`fld_o`=1) has FIELD_LINES+1. `fld_o` toggles at every field start, whether it comes from the line counter or from `vd_i`.
- R4: `vd_i` starts a new field at pixel 0 of line 0. `hd_i` without `vd_i` starts a new line at pixel 0, wrapping the field if the current line is the last one.
- R5: Phase p occupies `vlev_o[2p+1:2p]`, with V1 as p=0. The codes are low=00, mid=01 and readout-high=10. On line 0, slot A covers pixels [RD_START, RD_START+RD_WIDTH) and slot B starts RD_GAP pixels after slot A ends and has the same width. In odd fields V1 goes high in slot A and V3 in slot B. In even fields the two are swapped. At all other pixels of line 0 the pattern is idle.
- R6: On every line except line 0, the window [VT_START, VT_START+4*VT_STEP) has four steps. During step k (0..3) exactly phases (k+1) mod 4 and (k+2) mod 4 are mid and the other two are low. Outside the window the pattern is idle, with V1 and V2 mid and V3 and V4 low.
- R7: `sub_o` is high at pixels [SUB_START, SUB_START+SUB_WIDTH) of every line L with 1 <= L <= S, where S is the captured shutter value. S=0 gives no drain pulse.
- R8: `shut_i` is captured only at a field start. A change in mid-field does not affect that field's drain pulses.
- R9: Outside horizontal blanking, `h1_o` is 1 on even pixel positions and 0 on odd ones, and `h2_o` is its complement. During horizontal blanking `h1_o`=1 and `h2_o`=0. `rg_o` is 1 on every even pixel position.
- R10: `blk_o` is 1 when the pixel position is below HBLK_LEN or the line is below VBLK_LINES.
- R11: `sub_o` and any non-idle vertical pattern occur only while `blk_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, two cycles per pixel |
| rst_n | input | 1 | Asynchronous reset, active low |
| hd_i | input | 1 | Line restart strobe |
| vd_i | input | 1 | Field restart strobe |
| shut_i | input | SHUT_W | Last line that drains charge; 0 disables draining |
| vlev_o | output | 8 | Level codes for V4..V1, two bits each |
| h1_o | output | 1 | Horizontal phase 1 |
| h2_o | output | 1 | Horizontal phase 2 |
| rg_o | output | 1 | Reset-gate strobe |
| sub_o | output | 1 | Substrate drain strobe |
| blk_o | output | 1 | Blanking flag |
| fld_o | output | 1 | Field flag, 1 for even |

## Verification
The bench builds the block with 40-clock lines, 20 clocks of horizontal blanking and 10-line odd fields. A whole odd/even field pair then takes 840 clocks, so field-length, shutter-capture and wrap behaviour come up dozens of times in one run. The readout slots, transfer steps and drain window are only a few pixels wide, so every slot edge lands on a distinct pixel. Shutter values above the field length are also within reach, which checks that draining stops at the last line.

// File: rtl/ccdtg_pkg.sv
`timescale 1ns/1ps
package ccdtg_pkg;
    typedef enum logic [1:0] {
        LV_LOW = 2'b00,
        LV_MID = 2'b01,
        LV_RD  = 2'b10
    } vlev_e;

    // V4..V1 : low, low, mid, mid
    localparam logic [7:0] V_IDLE = 8'h05;
endpackage

// File: rtl/ccdtg_timebase.sv
`timescale 1ns/1ps
module ccdtg_timebase #(
    parameter int LINE_LEN    = 1820,
    parameter int FIELD_LINES = 517,
    parameter int SHUT_W      = 10,
    parameter int PW          = $clog2(LINE_LEN),
    parameter int LW          = $clog2(FIELD_LINES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hd_i,
    input  logic              vd_i,
    input  logic [SHUT_W-1:0] shut_i,
    output logic [PW-1:0]     pix_o,
    output logic [LW-1:0]     line_o,
    output logic              fld_o,
    output logic [SHUT_W-1:0] shut_o
);
    typedef struct packed {
        logic [PW-1:0]     pix;
        logic [LW-1:0]     line;
        logic              fld;
        logic [SHUT_W-1:0] shut;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic      line_end_d;
    logic      field_end_d;
    logic [31:0] last_line_d;

    always_comb begin
        st_d        = st_q;
        last_line_d = st_q.fld ? 32'(FIELD_LINES) : 32'(FIELD_LINES - 1);
        line_end_d  = hd_i || (32'(st_q.pix) == 32'(LINE_LEN - 1));
        field_end_d = (32'(st_q.line) == last_line_d);
        if (vd_i) begin
            st_d.pix  = '0;
            st_d.line = '0;
            st_d.fld  = ~st_q.fld;
            st_d.shut = shut_i;
        end else if (line_end_d) begin
            st_d.pix = '0;
            if (field_end_d) begin
                st_d.line = '0;
                st_d.fld  = ~st_q.fld;
                st_d.shut = shut_i;
            end else begin
                st_d.line = st_q.line + 1'b1;
            end
        end else begin
            st_d.pix = st_q.pix + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pix_o  = st_q.pix;
    assign line_o = st_q.line;
    assign fld_o  = st_q.fld;
    assign shut_o = st_q.shut;

    p_vd_flips_field_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vd_i |=> (st_q.fld != $past(st_q.fld)));

    p_hd_restarts_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hd_i && !vd_i) |=> (st_q.pix == '0));

    p_shut_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!vd_i && !line_end_d) |=> $stable(st_q.shut));
endmodule

// File: rtl/ccdtg_vdrive.sv
`timescale 1ns/1ps
module ccdtg_vdrive
    import ccdtg_pkg::*;
#(
    parameter int PW         = 11,
    parameter int LW         = 10,
    parameter int SHUT_W     = 10,
    parameter int RD_START   = 16,
    parameter int RD_WIDTH   = 72,
    parameter int RD_GAP     = 48,
    parameter int VT_START   = 16,
    parameter int VT_STEP    = 24,
    parameter int SUB_START  = 180,
    parameter int SUB_WIDTH  = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PW-1:0]     pix_i,
    input  logic [LW-1:0]     line_i,
    input  logic              fld_i,
    input  logic [SHUT_W-1:0] shut_i,
    output logic [7:0]        vlev_o,
    output logic              sub_o
);
    localparam int RD_B_START = RD_START + RD_WIDTH + RD_GAP;
    localparam int VT_END     = VT_START + 4 * VT_STEP;

    typedef struct packed {
        logic [7:0] v;
        logic       sub;
    } vd_state_t;

    vd_state_t   st_d, st_q;
    logic [31:0] p_d, l_d;
    logic        slot_a_d, slot_b_d;
    logic [1:0]  step_d, ph_a_d, ph_b_d;

    always_comb begin
        p_d      = 32'(pix_i);
        l_d      = 32'(line_i);
        slot_a_d = (p_d >= 32'(RD_START)) && (p_d < 32'(RD_START + RD_WIDTH));
        slot_b_d = (p_d >= 32'(RD_B_START)) && (p_d < 32'(RD_B_START + RD_WIDTH));
        step_d   = 2'd0;
        for (int k = 1; k < 4; k++) begin
            if (p_d >= 32'(VT_START + k * VT_STEP)) step_d = 2'(k);
        end
        ph_a_d = step_d + 2'd1;
        ph_b_d = step_d + 2'd2;

        st_d.v = V_IDLE;
        if (l_d == 32'd0) begin
            if (fld_i ? slot_b_d : slot_a_d) st_d.v[1:0] = LV_RD;
            if (fld_i ? slot_a_d : slot_b_d) st_d.v[5:4] = LV_RD;
        end else if ((p_d >= 32'(VT_START)) && (p_d < 32'(VT_END))) begin
            for (int ph = 0; ph < 4; ph++) begin
                if ((2'(ph) == ph_a_d) || (2'(ph) == ph_b_d)) begin
                    st_d.v[ph*2 +: 2] = LV_MID;
                end else begin
                    st_d.v[ph*2 +: 2] = LV_LOW;
                end
            end
        end

        st_d.sub = (l_d >= 32'd1) && (l_d <= 32'(shut_i)) &&
                   (p_d >= 32'(SUB_START)) && (p_d < 32'(SUB_START + SUB_WIDTH));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.v   <= V_IDLE;
            st_q.sub <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vlev_o = st_q.v;
    assign sub_o  = st_q.sub;

    p_one_readout_at_a_time_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !((st_q.v[1:0] == LV_RD) && (st_q.v[5:4] == LV_RD)));

    p_readout_only_line0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.v[1:0] == LV_RD) || (st_q.v[5:4] == LV_RD)) |-> ($past(line_i) == '0));
endmodule

// File: rtl/ccdtg_hdrive.sv
`timescale 1ns/1ps
module ccdtg_hdrive #(
    parameter int PW         = 11,
    parameter int LW         = 10,
    parameter int HBLK_LEN   = 320,
    parameter int VBLK_LINES = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] pix_i,
    input  logic [LW-1:0] line_i,
    output logic          h1_o,
    output logic          h2_o,
    output logic          rg_o,
    output logic          blk_o
);
    typedef struct packed {
        logic h1;
        logic h2;
        logic rg;
        logic blk;
    } hd_state_t;

    hd_state_t st_d, st_q;
    logic      hblank_d, vblank_d;

    always_comb begin
        hblank_d  = 32'(pix_i) < 32'(HBLK_LEN);
        vblank_d  = 32'(line_i) < 32'(VBLK_LINES);
        st_d.blk  = hblank_d || vblank_d;
        st_d.h1   = hblank_d || !pix_i[0];
        st_d.h2   = !hblank_d && pix_i[0];
        st_d.rg   = !pix_i[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.h1  <= 1'b1;
            st_q.h2  <= 1'b0;
            st_q.rg  <= 1'b0;
            st_q.blk <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign h1_o  = st_q.h1;
    assign h2_o  = st_q.h2;
    assign rg_o  = st_q.rg;
    assign blk_o = st_q.blk;
endmodule

// File: rtl/ccd_timing_gen.sv
`timescale 1ns/1ps
module ccd_timing_gen
    import ccdtg_pkg::*;
#(
    parameter int LINE_LEN   = 1820,
    parameter int HBLK_LEN   = 320,
    parameter int VBLK_LINES = 9,
    parameter int OB_FRONT   = 12,
    parameter int ACT_LINES  = 494,
    parameter int OB_REAR    = 2,
    parameter int RD_START   = 16,
    parameter int RD_WIDTH   = 72,
    parameter int RD_GAP     = 48,
    parameter int VT_START   = 16,
    parameter int VT_STEP    = 24,
    parameter int SUB_START  = 180,
    parameter int SUB_WIDTH  = 48,
    parameter int SHUT_W     = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hd_i,
    input  logic              vd_i,
    input  logic [SHUT_W-1:0] shut_i,
    output logic [7:0]        vlev_o,
    output logic              h1_o,
    output logic              h2_o,
    output logic              rg_o,
    output logic              sub_o,
    output logic              blk_o,
    output logic              fld_o
);
    localparam int FIELD_LINES = VBLK_LINES + OB_FRONT + ACT_LINES + OB_REAR;
    localparam int PW          = $clog2(LINE_LEN);
    localparam int LW          = $clog2(FIELD_LINES + 1);

    logic [PW-1:0]     pix_q;
    logic [LW-1:0]     line_q;
    logic              fld_q;
    logic [SHUT_W-1:0] shut_q;

    ccdtg_timebase #(
        .LINE_LEN(LINE_LEN), .FIELD_LINES(FIELD_LINES), .SHUT_W(SHUT_W),
        .PW(PW), .LW(LW)
    ) u_timebase (
        .clk(clk), .rst_n(rst_n), .hd_i(hd_i), .vd_i(vd_i), .shut_i(shut_i),
        .pix_o(pix_q), .line_o(line_q), .fld_o(fld_q), .shut_o(shut_q)
    );

    ccdtg_vdrive #(
        .PW(PW), .LW(LW), .SHUT_W(SHUT_W),
        .RD_START(RD_START), .RD_WIDTH(RD_WIDTH), .RD_GAP(RD_GAP),
        .VT_START(VT_START), .VT_STEP(VT_STEP),
        .SUB_START(SUB_START), .SUB_WIDTH(SUB_WIDTH)
    ) u_vdrive (
        .clk(clk), .rst_n(rst_n), .pix_i(pix_q), .line_i(line_q),
        .fld_i(fld_q), .shut_i(shut_q), .vlev_o(vlev_o), .sub_o(sub_o)
    );

    ccdtg_hdrive #(
        .PW(PW), .LW(LW), .HBLK_LEN(HBLK_LEN), .VBLK_LINES(VBLK_LINES)
    ) u_hdrive (
        .clk(clk), .rst_n(rst_n), .pix_i(pix_q), .line_i(line_q),
        .h1_o(h1_o), .h2_o(h2_o), .rg_o(rg_o), .blk_o(blk_o)
    );

    assign fld_o = fld_q;

    p_drain_in_blank_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sub_o |-> blk_o);

    p_vmove_in_blank_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (vlev_o != V_IDLE) |-> blk_o);

    p_hshift_toggles_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!blk_o && !$past(blk_o)) |-> (h1_o != $past(h1_o)));
endmodule

// File: tb/tb_ccd_timing_gen.sv
`timescale 1ns/1ps
module tb_ccd_timing_gen;
    localparam int LL   = 40;
    localparam int HB   = 20;
    localparam int VB   = 2;
    localparam int FL   = 10;
    localparam int RDS  = 2;
    localparam int RDW  = 5;
    localparam int RDG  = 2;
    localparam int VTS  = 2;
    localparam int VTP  = 2;
    localparam int SBS  = 12;
    localparam int SBW  = 4;
    localparam int SW   = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hd_i = 1'b0;
    logic          vd_i = 1'b0;
    logic [SW-1:0] shut_i = '0;
    logic [7:0]    vlev_o;
    logic          h1_o, h2_o, rg_o, sub_o, blk_o, fld_o;

    int n_checks = 0;
    int n_errors = 0;
    int m_pix = 0, m_line = 0, m_fld = 0, m_shut = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ccd_timing_gen #(
        .LINE_LEN(LL), .HBLK_LEN(HB), .VBLK_LINES(VB), .OB_FRONT(1),
        .ACT_LINES(6), .OB_REAR(1), .RD_START(RDS), .RD_WIDTH(RDW),
        .RD_GAP(RDG), .VT_START(VTS), .VT_STEP(VTP), .SUB_START(SBS),
        .SUB_WIDTH(SBW), .SHUT_W(SW)
    ) dut (
        .clk(clk), .rst_n(rst_n), .hd_i(hd_i), .vd_i(vd_i), .shut_i(shut_i),
        .vlev_o(vlev_o), .h1_o(h1_o), .h2_o(h2_o), .rg_o(rg_o),
        .sub_o(sub_o), .blk_o(blk_o), .fld_o(fld_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_v(int p, int l, int f);
        logic [7:0] v;
        bit ra, rb;
        int k;
        v = 8'h05;
        if (l == 0) begin
            ra = (p >= RDS) && (p < RDS + RDW);
            rb = (p >= RDS + RDW + RDG) && (p < RDS + 2 * RDW + RDG);
            if (f ? rb : ra) v[1:0] = 2'b10;
            if (f ? ra : rb) v[5:4] = 2'b10;
        end else if (p >= VTS && p < VTS + 4 * VTP) begin
            k = (p - VTS) / VTP;
            v = 8'h00;
            v[((k + 1) % 4) * 2 +: 2] = 2'b01;
            v[((k + 2) % 4) * 2 +: 2] = 2'b01;
        end
        return v;
    endfunction

    function automatic bit exp_sub(int p, int l, int s);
        return (l >= 1) && (l <= s) && (p >= SBS) && (p < SBS + SBW);
    endfunction

    task automatic model_step(input bit hd, input bit vd, input int sh);
        int last;
        last = m_fld ? FL : FL - 1;
        if (vd) begin
            m_pix = 0; m_line = 0; m_fld ^= 1; m_shut = sh;
        end else if (hd || m_pix == LL - 1) begin
            m_pix = 0;
            if (m_line == last) begin
                m_line = 0; m_fld ^= 1; m_shut = sh;
            end else begin
                m_line++;
            end
        end else begin
            m_pix++;
        end
    endtask

    // Called just after a falling edge; ends just after the next falling edge.
    task automatic cycle(input bit hd, input bit vd, input int sh);
        logic [7:0] ev;
        bit es, hb, eh1;
        int p, l;
        hd_i = hd; vd_i = vd; shut_i = SW'(sh);
        p = m_pix; l = m_line;
        ev  = exp_v(p, l, m_fld);
        es  = exp_sub(p, l, m_shut);
        hb  = p < HB;
        eh1 = hb || (p % 2 == 0);
        @(posedge clk);
        #1;
        model_step(hd, vd, sh);
        chk(l == 0 ? "R5 readout" : "R6 transfer", vlev_o, ev);
        chk("R7/R8 drain", sub_o, es);
        chk("R9 h1", h1_o, eh1);
        chk("R9 h2", h2_o, !eh1);
        chk("R9 rg", rg_o, (p % 2 == 0));
        chk("R10/R2/R4 blk", blk_o, hb || (l < VB));
        chk("R3/R4 fld", fld_o, m_fld);
        @(negedge clk);
    endtask

    task automatic run_field(input int sh, output int len, output int drains);
        bit f0;
        f0 = fld_o;
        len = 0; drains = 0;
        do begin
            cycle(1'b0, 1'b0, sh);
            len++;
            if (sub_o) drains++;
        end while (fld_o == f0 && len < 5000);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL R2 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int len, dr, hd, vd, sh;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 vlev", vlev_o, 8'h05);
        chk("R1 h1", h1_o, 1);
        chk("R1 h2", h2_o, 0);
        chk("R1 rg", rg_o, 0);
        chk("R1 sub", sub_o, 0);
        chk("R1 blk", blk_o, 1);
        chk("R1 fld", fld_o, 0);
        rst_n = 1'b1;

        // R3: odd then even field lengths, R7: no drain with S=0
        run_field(0, len, dr);
        chk("R3 odd field length", len, LL * FL);
        chk("R7 no drain when zero", dr, 0);
        run_field(0, len, dr);
        chk("R3 even field length", len, LL * (FL + 1));
        // R8: value presented during the field is not yet in use
        run_field(3, len, dr);
        chk("R8 mid-field change ignored", dr, 0);
        run_field(7, len, dr);
        chk("R7 drain count S=3 even", dr, 3 * SBW);
        run_field(200, len, dr);
        chk("R7 drain count S=7 odd", dr, 7 * SBW);
        run_field(1, len, dr);
        chk("R7 drain covers all lines", dr, FL * SBW);

        // R4: directed strobes
        repeat (55) cycle(1'b0, 1'b0, 1);
        cycle(1'b1, 1'b0, 1);
        repeat (30) cycle(1'b0, 1'b0, 1);
        cycle(1'b0, 1'b1, 2);
        cycle(1'b1, 1'b1, 2);
        repeat (100) cycle(1'b0, 1'b0, 2);

        // random mix
        sh = 2;
        for (int i = 0; i < 40000; i++) begin
            hd = ($urandom % 90) == 0;
            vd = ($urandom % 1300) == 0;
            if (($urandom % 400) == 0) sh = $urandom % 14;
            cycle(hd[0], vd[0], sh);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule